// File: doc/BRIEF.md
# Well-Known Region Checker

This block is a fast-path protection check that sits beside the protection lookaside buffer. It keeps five region descriptors in registers: three that belong to the running protection domain (code, initialized data, constant pool) and two that belong to the running thread (stack and thread-local storage). Each cycle it may take one access, made up of an address and an access kind. One cycle later it reports one of three outcomes. The access may be permitted by a register region, refused by a register region, or handed to the lookaside buffer because no register region covers it.

Each region is a half-open byte range `[lo, hi)`. The rights are fixed by the region's role. Code may only be executed. The constant pool may only be read. Data, stack and thread-local storage may be read and written. The stack is special. Its descriptor gives the base and the reserved limit, but only the part below the live stack pointer `sp` is usable. Bytes at or above `sp` are refused, even when they held a frame a moment earlier. `sp` is a live input, so the usable stack follows every call and return without a reload.

A call sequencer uses two load ports and one save port to swap register sets. The domain load port replaces all three domain descriptors in a single cycle. The thread load port replaces both thread descriptors. The save port shows all five descriptors at all times.

Top module: `wkr_checker`

## Requirements
- R1: After reset, every saved descriptor bound on `sv_lo`/`sv_hi` is zero, so all regions are empty. `rsp_valid` and `fwd_valid` are 0.
- R2: Each cycle with `req_valid` high gives exactly one response with `rsp_valid` high in the next cycle. A cycle without a request gives `rsp_valid`=0 and `rsp_code`=0 in the next cycle. Kind encoding: 0 read, 1 write, 2 execute. Code encoding: 1 permit, 2 fault, 3 fall-through.
- R3: The code region (index 0) permits execute and faults on read and write.
- R4: The constant-pool region (index 2) permits read and faults on write and execute.
- R5: The data region (index 1) and the thread-local region (index 4) permit read and write and fault on execute.
- R6: Inside the stack descriptor (index 3), an address below `sp` permits read and write. An address at or above `sp` and below the stack limit faults for every kind.
- R7: Lowering `sp` makes the bytes just released fault on the very next request, with no descriptor load. Raising `sp` makes them usable again.
- R8: An address outside every region gives code 3 and `rsp_region`=7, with `fwd_valid`=1 and `fwd_addr` equal to the request address. Every other response has `fwd_valid`=0.
- R9: When regions overlap, the lowest index that contains the address decides both the outcome and `rsp_region`. Region bounds are inclusive at `lo` and exclusive at `hi`.
- R10: A pulse on `turf_ld` replaces descriptors 0 to 2 together on the next edge and leaves 3 and 4 unchanged. A request made in the same cycle as the load is still checked against the old descriptors.
- R11: A pulse on `thr_ld` replaces descriptors 3 and 4 and leaves 0 to 2 unchanged.
- R12: `sv_lo[i]`/`sv_hi[i]` show descriptor i in index order: 0 code, 1 data, 2 constant pool, 3 stack, 4 thread-local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp | input | AW | Live stack pointer, the exclusive top of the usable stack |
| turf_ld | input | 1 | Load the three domain descriptors |
| turf_lo | input | 3 x AW | New lower bounds: code, data, constant pool |
| turf_hi | input | 3 x AW | New exclusive upper bounds: code, data, constant pool |
| thr_ld | input | 1 | Load the two thread descriptors |
| thr_lo | input | 2 x AW | New lower bounds: stack, thread-local |
| thr_hi | input | 2 x AW | New exclusive upper bounds: stack limit, thread-local |
| req_valid | input | 1 | Access present |
| req_addr | input | AW | Access byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_code | output | 2 | 0 none, 1 permit, 2 fault, 3 fall-through |
| rsp_region | output | 3 | Index of the deciding region, 7 if none |
| fwd_valid | output | 1 | Access forwarded to the lookaside buffer |
| fwd_addr | output | AW | Forwarded address |
| sv_lo | output | 5 x AW | Saved lower bounds in index order |
| sv_hi | output | 5 x AW | Saved upper bounds in index order |

## Verification
Every region is tried with all three access kinds. This separates the fixed rights table per region from a single shared rule. Addresses one below `lo`, at `lo`, one below `hi` and at `hi` show whether the bounds are half-open, and a region that overlaps code shows whether priority goes by index. The stack is probed around a moving `sp`, which tells the live bound apart from the stored limit. Loads issued together with a request, followed by a read of the save port, separate the old and new register sets and show that each load port touches only its own group.

// File: rtl/wkr_pkg.sv
package wkr_pkg;
  localparam int NUM_TURF  = 3;
  localparam int NUM_THR   = 2;
  localparam int NUM_WKR   = NUM_TURF + NUM_THR;
  localparam int RIDX_W    = 3;
  localparam int STACK_IDX = NUM_TURF;
  localparam logic [RIDX_W-1:0] REG_NONE = '1;

  typedef enum logic [1:0] {
    KIND_RD = 2'd0,
    KIND_WR = 2'd1,
    KIND_EX = 2'd2
  } wkr_kind_e;

  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_PERMIT = 2'd1,
    RES_FAULT  = 2'd2,
    RES_FALL   = 2'd3
  } wkr_res_e;

  // rights as {exec, write, read}
  function automatic logic [2:0] wkr_rights(input int idx);
    case (idx)
      0:       return 3'b100;
      2:       return 3'b001;
      default: return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/wkr_bank.sv
module wkr_bank #(
  parameter int AW = 32,
  parameter int N  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [N-1:0][AW-1:0] ld_lo,
  input  logic [N-1:0][AW-1:0] ld_hi,
  output logic [N-1:0][AW-1:0] lo,
  output logic [N-1:0][AW-1:0] hi
);
  logic [N-1:0][AW-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = lo;
    hi_d = hi;
    if (ld) begin
      lo_d = ld_lo;
      hi_d = ld_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end
endmodule

// File: rtl/wkr_match.sv
module wkr_match #(
  parameter int AW       = 32,
  parameter bit IS_STACK = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] sp,
  output logic          hit,
  output logic          live
);
  logic below_sp;

  always_comb begin
    hit      = (addr >= lo) && (addr < hi);
    below_sp = addr < sp;
    live     = hit && (IS_STACK ? below_sp : 1'b1);
  end
endmodule

// File: rtl/wkr_resolve.sv
module wkr_resolve
  import wkr_pkg::*;
(
  input  logic [NUM_WKR-1:0] hit,
  input  logic [NUM_WKR-1:0] live,
  input  logic [1:0]         kind,
  output logic [1:0]         code,
  output logic [RIDX_W-1:0]  region
);
  logic [NUM_WKR-1:0] allow;

  for (genvar g = 0; g < NUM_WKR; g++) begin : g_allow
    localparam logic [2:0] RIGHTS = wkr_rights(g);
    logic kind_ok;
    always_comb begin
      case (kind)
        KIND_RD: kind_ok = RIGHTS[0];
        KIND_WR: kind_ok = RIGHTS[1];
        KIND_EX: kind_ok = RIGHTS[2];
        default: kind_ok = 1'b0;
      endcase
      allow[g] = live[g] && kind_ok;
    end
  end

  // scan from the top so the lowest matching index wins
  always_comb begin
    code   = RES_FALL;
    region = REG_NONE;
    for (int i = NUM_WKR - 1; i >= 0; i--) begin
      if (hit[i]) begin
        code   = allow[i] ? RES_PERMIT : RES_FAULT;
        region = RIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wkr_checker.sv
module wkr_checker
  import wkr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               sp,
  input  logic                        turf_ld,
  input  logic [NUM_TURF-1:0][AW-1:0] turf_lo,
  input  logic [NUM_TURF-1:0][AW-1:0] turf_hi,
  input  logic                        thr_ld,
  input  logic [NUM_THR-1:0][AW-1:0]  thr_lo,
  input  logic [NUM_THR-1:0][AW-1:0]  thr_hi,
  input  logic                        req_valid,
  input  logic [AW-1:0]               req_addr,
  input  logic [1:0]                  req_kind,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_code,
  output logic [RIDX_W-1:0]           rsp_region,
  output logic                        fwd_valid,
  output logic [AW-1:0]               fwd_addr,
  output logic [NUM_WKR-1:0][AW-1:0]  sv_lo,
  output logic [NUM_WKR-1:0][AW-1:0]  sv_hi
);
  logic [NUM_TURF-1:0][AW-1:0] t_lo, t_hi;
  logic [NUM_THR-1:0][AW-1:0]  h_lo, h_hi;
  logic [NUM_WKR-1:0][AW-1:0]  all_lo, all_hi;
  logic [NUM_WKR-1:0]          hit, live;
  logic [1:0]                  res_code;
  logic [RIDX_W-1:0]           res_region;

  logic                rsp_valid_d, fwd_valid_d;
  logic [1:0]          rsp_code_d;
  logic [RIDX_W-1:0]   rsp_region_d;
  logic [AW-1:0]       fwd_addr_d;

  wkr_bank #(.AW(AW), .N(NUM_TURF)) u_turf_bank (
    .clk(clk), .rst_n(rst_n), .ld(turf_ld),
    .ld_lo(turf_lo), .ld_hi(turf_hi), .lo(t_lo), .hi(t_hi)
  );

  wkr_bank #(.AW(AW), .N(NUM_THR)) u_thr_bank (
    .clk(clk), .rst_n(rst_n), .ld(thr_ld),
    .ld_lo(thr_lo), .ld_hi(thr_hi), .lo(h_lo), .hi(h_hi)
  );

  always_comb begin
    all_lo = {h_lo, t_lo};
    all_hi = {h_hi, t_hi};
  end

  for (genvar g = 0; g < NUM_WKR; g++) begin : g_match
    wkr_match #(.AW(AW), .IS_STACK(g == STACK_IDX)) u_match (
      .addr(req_addr), .lo(all_lo[g]), .hi(all_hi[g]), .sp(sp),
      .hit(hit[g]), .live(live[g])
    );
  end

  wkr_resolve u_resolve (
    .hit(hit), .live(live), .kind(req_kind),
    .code(res_code), .region(res_region)
  );

  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_code_d   = req_valid ? res_code : RES_NONE;
    rsp_region_d = req_valid ? res_region : REG_NONE;
    fwd_valid_d  = req_valid && (res_code == RES_FALL);
    fwd_addr_d   = fwd_addr;
    if (req_valid) fwd_addr_d = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= RES_NONE;
      rsp_region <= REG_NONE;
      fwd_valid  <= 1'b0;
      fwd_addr   <= '0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_code   <= rsp_code_d;
      rsp_region <= rsp_region_d;
      fwd_valid  <= fwd_valid_d;
      fwd_addr   <= fwd_addr_d;
    end
  end

  always_comb begin
    sv_lo = all_lo;
    sv_hi = all_hi;
  end
endmodule

// File: rtl/wkr_checker_sva.sv
module wkr_checker_sva
  import wkr_pkg::*;
#(
  parameter int AW = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [AW-1:0]               sp,
  input logic                        turf_ld,
  input logic [NUM_TURF-1:0][AW-1:0] turf_lo,
  input logic [NUM_TURF-1:0][AW-1:0] turf_hi,
  input logic                        thr_ld,
  input logic                        req_valid,
  input logic [AW-1:0]               req_addr,
  input logic [1:0]                  req_kind,
  input logic                        rsp_valid,
  input logic [1:0]                  rsp_code,
  input logic [RIDX_W-1:0]           rsp_region,
  input logic                        fwd_valid,
  input logic [AW-1:0]               fwd_addr,
  input logic [NUM_WKR-1:0][AW-1:0]  sv_lo,
  input logic [NUM_WKR-1:0][AW-1:0]  sv_hi
);
  assert_one_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && rsp_code != RES_NONE);

  assert_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && rsp_code == RES_NONE && !fwd_valid);

  assert_fwd_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (fwd_valid == (rsp_code == RES_FALL)) &&
                  (!fwd_valid || fwd_addr == $past(req_addr)));

  assert_exec_code_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == KIND_EX |=>
      rsp_code != RES_PERMIT || rsp_region == 3'd0);

  assert_stack_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= sp |=>
      rsp_region != 3'(STACK_IDX) || rsp_code == RES_FAULT);

  assert_turf_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    turf_ld && !thr_ld |=>
      sv_lo[NUM_TURF-1:0] == $past(turf_lo) &&
      sv_hi[NUM_TURF-1:0] == $past(turf_hi) &&
      $stable(sv_lo[NUM_WKR-1:NUM_TURF]) && $stable(sv_hi[NUM_WKR-1:NUM_TURF]));

  assert_thr_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ld && !turf_ld |=>
      $stable(sv_lo[NUM_TURF-1:0]) && $stable(sv_hi[NUM_TURF-1:0]));
endmodule

bind wkr_checker wkr_checker_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .sp(sp), .turf_ld(turf_ld),
  .turf_lo(turf_lo), .turf_hi(turf_hi), .thr_ld(thr_ld),
  .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_region(rsp_region),
  .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .sv_lo(sv_lo), .sv_hi(sv_hi)
);

// File: tb/test_wkr_checker.sv
`timescale 1ns/1ps
module test_wkr_checker;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] sp;
  logic turf_ld, thr_ld;
  logic [2:0][AW-1:0] turf_lo, turf_hi;
  logic [1:0][AW-1:0] thr_lo, thr_hi;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0] req_kind;
  logic rsp_valid, fwd_valid;
  logic [1:0] rsp_code;
  logic [2:0] rsp_region;
  logic [AW-1:0] fwd_addr;
  logic [4:0][AW-1:0] sv_lo, sv_hi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wkr_checker #(.AW(AW)) i_wkr_checker (
    .clk(clk), .rst_n(rst_n), .sp(sp),
    .turf_ld(turf_ld), .turf_lo(turf_lo), .turf_hi(turf_hi),
    .thr_ld(thr_ld), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_region(rsp_region),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .sv_lo(sv_lo), .sv_hi(sv_hi)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // kind 0 rd, 1 wr, 2 ex; code 1 permit, 2 fault, 3 fall
  task automatic access(input logic [AW-1:0] a, input logic [1:0] k,
                        input logic [1:0] ec, input logic [2:0] er,
                        input string req);
    logic ef;
    ef = (ec == 2'd3);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_code == ec && rsp_region == er &&
          fwd_valid == ef && (!ef || fwd_addr == a), req,
          $sformatf("addr=%h kind=%0d act v=%0b code=%0d reg=%0d fwd=%0b/%h exp code=%0d reg=%0d fwd=%0b",
                    a, k, rsp_valid, rsp_code, rsp_region, fwd_valid, fwd_addr, ec, er, ef));
  endtask

  task automatic load_turf(input logic [AW-1:0] l0, h0, l1, h1, l2, h2);
    @(negedge clk);
    turf_ld = 1'b1;
    turf_lo = {l2, l1, l0};
    turf_hi = {h2, h1, h0};
    @(negedge clk);
    turf_ld = 1'b0;
  endtask

  task automatic load_thr(input logic [AW-1:0] l0, h0, l1, h1);
    @(negedge clk);
    thr_ld = 1'b1;
    thr_lo = {l1, l0};
    thr_hi = {h1, h0};
    @(negedge clk);
    thr_ld = 1'b0;
  endtask

  task automatic t_reset;
    check(sv_lo == '0 && sv_hi == '0, "R1", $sformatf("act lo=%h hi=%h exp 0", sv_lo, sv_hi));
    check(!rsp_valid && !fwd_valid, "R1", $sformatf("act rsp_v=%0b fwd_v=%0b exp 0 0", rsp_valid, fwd_valid));
    @(negedge clk);
    check(!rsp_valid && rsp_code == 2'd0, "R2", $sformatf("idle act v=%0b code=%0d exp 0 0", rsp_valid, rsp_code));
    access(32'h0000_0000, 2'd0, 2'd3, 3'd7, "R1");
  endtask

  task automatic t_setup;
    load_turf(32'h1000, 32'h2000, 32'h4000, 32'h5000, 32'h3000, 32'h3400);
    load_thr(32'h8000, 32'h9000, 32'hA000, 32'hA100);
    sp = 32'h8400;
  endtask

  task automatic t_save_r12;
    @(negedge clk);
    check(sv_lo[0] == 32'h1000 && sv_hi[0] == 32'h2000 &&
          sv_lo[1] == 32'h4000 && sv_hi[1] == 32'h5000 &&
          sv_lo[2] == 32'h3000 && sv_hi[2] == 32'h3400 &&
          sv_lo[3] == 32'h8000 && sv_hi[3] == 32'h9000 &&
          sv_lo[4] == 32'hA000 && sv_hi[4] == 32'hA100, "R12",
          $sformatf("act lo=%h hi=%h", sv_lo, sv_hi));
  endtask

  task automatic t_code_r3;
    access(32'h1800, 2'd2, 2'd1, 3'd0, "R3");
    access(32'h1800, 2'd0, 2'd2, 3'd0, "R3");
    access(32'h1800, 2'd1, 2'd2, 3'd0, "R3");
  endtask

  task automatic t_cpool_r4;
    access(32'h3100, 2'd0, 2'd1, 3'd2, "R4");
    access(32'h3100, 2'd1, 2'd2, 3'd2, "R4");
    access(32'h3100, 2'd2, 2'd2, 3'd2, "R4");
  endtask

  task automatic t_data_r5;
    access(32'h4800, 2'd0, 2'd1, 3'd1, "R5");
    access(32'h4800, 2'd1, 2'd1, 3'd1, "R5");
    access(32'h4800, 2'd2, 2'd2, 3'd1, "R5");
    access(32'hA010, 2'd1, 2'd1, 3'd4, "R5");
    access(32'hA010, 2'd2, 2'd2, 3'd4, "R5");
  endtask

  task automatic t_stack_r6;
    access(32'h8000, 2'd1, 2'd1, 3'd3, "R6");
    access(32'h83FF, 2'd0, 2'd1, 3'd3, "R6");
    access(32'h8400, 2'd0, 2'd2, 3'd3, "R6");
    access(32'h8F00, 2'd1, 2'd2, 3'd3, "R6");
    access(32'h8100, 2'd2, 2'd2, 3'd3, "R6");
  endtask

  task automatic t_stack_move_r7;
    @(negedge clk); sp = 32'h8200;
    access(32'h8300, 2'd0, 2'd2, 3'd3, "R7");
    access(32'h81FF, 2'd1, 2'd1, 3'd3, "R7");
    @(negedge clk); sp = 32'h8600;
    access(32'h8300, 2'd0, 2'd1, 3'd3, "R7");
    access(32'h8500, 2'd1, 2'd1, 3'd3, "R7");
    @(negedge clk); sp = 32'h8400;
  endtask

  task automatic t_fall_r8;
    access(32'h0FFF, 2'd2, 2'd3, 3'd7, "R8");
    access(32'h2000, 2'd2, 2'd3, 3'd7, "R8");
    access(32'h9000, 2'd0, 2'd3, 3'd7, "R8");
    access(32'hDEAD_0000, 2'd1, 2'd3, 3'd7, "R8");
  endtask

  task automatic t_bounds_r9;
    access(32'h1000, 2'd2, 2'd1, 3'd0, "R9");
    access(32'h1FFF, 2'd2, 2'd1, 3'd0, "R9");
    access(32'h33FF, 2'd0, 2'd1, 3'd2, "R9");
    access(32'h3400, 2'd0, 2'd3, 3'd7, "R9");
  endtask

  task automatic t_priority_r9;
    load_turf(32'h1000, 32'h2000, 32'h1800, 32'h2800, 32'h1C00, 32'h3000);
    access(32'h1900, 2'd0, 2'd2, 3'd0, "R9");
    access(32'h1900, 2'd2, 2'd1, 3'd0, "R9");
    access(32'h2100, 2'd1, 2'd1, 3'd1, "R9");
    access(32'h2900, 2'd0, 2'd1, 3'd2, "R9");
    load_turf(32'h1000, 32'h2000, 32'h4000, 32'h5000, 32'h3000, 32'h3400);
  endtask

  task automatic t_turf_load_r10;
    @(negedge clk);
    turf_ld = 1'b1;
    turf_lo = {32'h3000, 32'h4000, 32'h6000};
    turf_hi = {32'h3400, 32'h5000, 32'h7000};
    req_valid = 1'b1; req_addr = 32'h1000; req_kind = 2'd2;
    @(negedge clk);
    turf_ld = 1'b0; req_valid = 1'b0;
    check(rsp_valid && rsp_code == 2'd1 && rsp_region == 3'd0, "R10",
          $sformatf("same-cycle act code=%0d reg=%0d exp 1 0", rsp_code, rsp_region));
    check(sv_lo[0] == 32'h6000 && sv_hi[0] == 32'h7000 &&
          sv_lo[3] == 32'h8000 && sv_hi[3] == 32'h9000 &&
          sv_lo[4] == 32'hA000 && sv_hi[4] == 32'hA100, "R10",
          $sformatf("act lo=%h hi=%h", sv_lo, sv_hi));
    access(32'h1000, 2'd2, 2'd3, 3'd7, "R10");
    access(32'h6000, 2'd2, 2'd1, 3'd0, "R10");
  endtask

  task automatic t_thr_load_r11;
    load_thr(32'hB000, 32'hC000, 32'hD000, 32'hD100);
    sp = 32'hB100;
    @(negedge clk);
    check(sv_lo[3] == 32'hB000 && sv_hi[3] == 32'hC000 &&
          sv_lo[4] == 32'hD000 && sv_hi[4] == 32'hD100 &&
          sv_lo[0] == 32'h6000 && sv_hi[0] == 32'h7000 &&
          sv_lo[2] == 32'h3000 && sv_hi[2] == 32'h3400, "R11",
          $sformatf("act lo=%h hi=%h", sv_lo, sv_hi));
    access(32'h8100, 2'd0, 2'd3, 3'd7, "R11");
    access(32'hB050, 2'd1, 2'd1, 3'd3, "R11");
  endtask

  initial begin
    rst_n = 1'b0; sp = '0;
    turf_ld = 1'b0; thr_ld = 1'b0;
    turf_lo = '0; turf_hi = '0; thr_lo = '0; thr_hi = '0;
    req_valid = 1'b0; req_addr = '0; req_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_save_r12();
    t_code_r3();
    t_cpool_r4();
    t_data_r5();
    t_stack_r6();
    t_stack_move_r7();
    t_fall_r8();
    t_bounds_r9();
    t_priority_r9();
    t_turf_load_r10();
    t_thr_load_r11();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule